// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block models a byte-wide static RAM in which every word has a shadow nonvolatile copy. A controller copies the whole array in either direction. STORE copies the working SRAM into the shadow. RECALL wipes the SRAM and then reloads it from the shadow. The host reaches the array through a synchronous model of an SRAM port. Each clock in which chip enable is low is one access. Write enable picks a write or a read, and output enable gates the read data. Read data is registered and appears one clock after the access.

A transfer can start from four sources:
- Power-good falling starts a STORE.
- Power-good rising out of reset starts a RECALL.
- Holding the active-low store/busy line low starts a STORE.
- Six consecutive chip-enabled reads at fixed addresses start a software STORE or RECALL.

While a transfer runs, or while the block waits for power, the controller ignores host traffic. During that time it raises `busy` and pulls the store/busy line low. The line is open-drain, so the bench models it as a wired-AND.

The controller has seven states. OFF waits for power. IDLE serves the host. SSETUP and SCOPY are the STORE overhead and copy phases. RSETUP, RCLEAR and RCOPY are the RECALL overhead, wipe and reload phases. The transitions are:
- OFF→RSETUP on power-good.
- IDLE→SSETUP on power loss when dirty, on the line being low, or on a completed store sequence when dirty.
- IDLE→OFF on power loss when clean.
- IDLE→RSETUP on a completed recall sequence.
- SSETUP→SCOPY, RSETUP→RCLEAR and RCLEAR→RCOPY when each phase's count expires.
- SCOPY or RCOPY→IDLE when power is good, otherwise →OFF.

Top module: `nvsram_ctl`

## Requirements
- R1: In IDLE with power good and the store/busy line high, a clock with `ce_n`=0 and `we_n`=0 writes `din` to word `addr mod DEPTH`. A clock with `ce_n`=0 and `we_n`=1 is a read: on the next clock `dout` holds that word and `dout_en` equals `~oe_n`. Otherwise `dout_en` is 0.
- R2: Six consecutive chip-enabled reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 (full 15-bit address) start a STORE when the array is dirty. Afterwards the shadow equals the SRAM.
- R3: The same first five addresses followed by 0x0C63 start a RECALL. Afterwards the SRAM equals the shadow.
- R4: A write, or a read at an address that is not the expected next step, aborts the sequence. A read at 0x0E38 restarts it at step two. Clocks with `ce_n`=1 do not abort.
- R5: While `busy` is 1, writes are dropped and reads give `dout_en`=0 and `dout`=0 (from the second busy clock on). `hsb_drive_low` is 1.
- R6: `busy` rises on the clock after the trigger. It lasts OVH+DEPTH clocks for a STORE and OVH+2·DEPTH clocks for a RECALL.
- R7: A RECALL leaves the shadow unchanged, so repeated RECALLs reproduce the same SRAM contents.
- R8: `hsb_in` low in IDLE starts a STORE even when the array is clean.
- R9: A software or power-loss STORE is skipped when no write has been accepted since the last STORE or RECALL.
- R10: From reset the block sits in OFF with `busy`=1 until `pwr_good` is 1, then runs a RECALL. `pwr_good` low in IDLE runs a STORE if dirty, then enters OFF.
- R11: A host access in the clock where `pwr_good` or `hsb_in` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Host word address |
| din | input | 8 | Host write data |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | Read data valid (output enable) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hsb_in | input | 1 | Sensed level of the store/busy line |
| hsb_drive_low | output | 1 | Pulls the store/busy line low |
| pwr_good | input | 1 | Supply good |
| busy | output | 1 | Transfer or power wait in progress |

## Verification
The bench builds the block with DEPTH=16 and OVH=3, keeping ADDR_W at 15. The command addresses therefore keep their full width, while they fold onto a 16-word array. A whole-array readback after every transfer takes only 16 reads. Every busy window, including RECALL at 35 clocks, is short enough to check clock by clock. Among those checks, each attempted write or read during the window is confirmed to be ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_SSETUP,
        ST_SCOPY,
        ST_RSETUP,
        ST_RCLEAR,
        ST_RCOPY
    } nvs_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SAVE,
        OP_WIPE,
        OP_LOAD
    } nvs_op_e;

    localparam logic [14:0] CMD_SAVE_LAST = 15'h0FC0;
    localparam logic [14:0] CMD_LOAD_LAST = 15'h0C63;

    // Shared prefix of both command sequences, steps 0..4.
    function automatic logic [14:0] cmd_addr(input logic [2:0] step);
        logic [14:0] a;
        unique case (step)
            3'd0:    a = 15'h0E38;
            3'd1:    a = 15'h31C7;
            3'd2:    a = 15'h03E0;
            3'd3:    a = 15'h3C1F;
            3'd4:    a = 15'h303F;
            default: a = 15'h7FFF;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nvs_cmd_detect.sv
module nvs_cmd_detect
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              acc,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              save_hit,
    output logic              load_hit
);

    localparam logic [2:0] LAST_STEP = 3'd5;

    logic [2:0] step_q, step_d;
    logic       first_m, next_m, save_m, load_m;

    always_comb begin
        first_m  = (addr == ADDR_W'(cmd_addr(3'd0)));
        next_m   = (addr == ADDR_W'(cmd_addr(step_q)));
        save_m   = (step_q == LAST_STEP) && (addr == ADDR_W'(CMD_SAVE_LAST));
        load_m   = (step_q == LAST_STEP) && (addr == ADDR_W'(CMD_LOAD_LAST));
        save_hit = enable && rd && save_m;
        load_hit = enable && rd && load_m;
        step_d   = step_q;
        if (!enable) begin
            step_d = 3'd0;
        end else if (acc) begin
            if (!rd) begin
                step_d = 3'd0;
            end else if (step_q == LAST_STEP) begin
                step_d = first_m ? 3'd1 : 3'd0;
            end else if (next_m) begin
                step_d = step_q + 3'd1;
            end else if (first_m) begin
                step_d = 3'd1;
            end else begin
                step_d = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 3'd0;
        else        step_q <= step_d;
    end

    a_r4_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && acc && !rd) |=> (step_q == 3'd0));

    a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST_STEP);

    a_r4_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (step_q == 3'd0));

endmodule

// File: rtl/nvs_ctrl_fsm.sv
module nvs_ctrl_fsm
    import nvs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OVH   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_good,
    input  logic                     hsb_in,
    input  logic                     save_req,
    input  logic                     load_req,
    input  logic                     wr_accept,
    output nvs_state_e               state_q,
    output logic                     busy,
    output logic                     hsb_drive_low,
    output nvs_op_e                  op,
    output logic [$clog2(DEPTH)-1:0] xidx
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int SPAN  = (DEPTH > OVH) ? DEPTH : OVH;
    localparam int CNT_W = $clog2(SPAN) + 1;
    localparam logic [CNT_W-1:0] OVH_END = CNT_W'(OVH - 1);
    localparam logic [CNT_W-1:0] ARR_END = CNT_W'(DEPTH - 1);

    nvs_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             dirty_q, dirty_d;
    logic             start_xfer;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (pwr_good) state_d = ST_RSETUP;
            ST_IDLE: begin
                if (!pwr_good)                state_d = dirty_q ? ST_SSETUP : ST_OFF;
                else if (!hsb_in)             state_d = ST_SSETUP;
                else if (save_req && dirty_q) state_d = ST_SSETUP;
                else if (load_req)            state_d = ST_RSETUP;
            end
            ST_SSETUP: if (cnt_q == OVH_END) state_d = ST_SCOPY;
            ST_SCOPY:  if (cnt_q == ARR_END) state_d = pwr_good ? ST_IDLE : ST_OFF;
            ST_RSETUP: if (cnt_q == OVH_END) state_d = ST_RCLEAR;
            ST_RCLEAR: if (cnt_q == ARR_END) state_d = ST_RCOPY;
            ST_RCOPY:  if (cnt_q == ARR_END) state_d = pwr_good ? ST_IDLE : ST_OFF;
            default:   state_d = ST_OFF;
        endcase
        start_xfer = (state_d == ST_SSETUP || state_d == ST_RSETUP) &&
                     (state_q == ST_IDLE || state_q == ST_OFF);
        dirty_d = dirty_q;
        if (start_xfer)     dirty_d = 1'b0;
        else if (wr_accept) dirty_d = 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            dirty_q <= dirty_d;
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        hsb_drive_low = busy;
        xidx          = cnt_q[IDX_W-1:0];
        unique case (state_q)
            ST_SCOPY:  op = OP_SAVE;
            ST_RCLEAR: op = OP_WIPE;
            ST_RCOPY:  op = OP_LOAD;
            default:   op = OP_NONE;
        endcase
    end

    a_r10_off_until_power: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !pwr_good) |=> (state_q == ST_OFF));

    a_r10_power_loss_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pwr_good) |=> (state_q != ST_IDLE));

    a_r7_wipe_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RCOPY) |-> ($past(state_q) == ST_RCLEAR || $past(state_q) == ST_RCOPY));

    a_r9_clean_save_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pwr_good && hsb_in && save_req && !dirty_q) |=> (state_q == ST_IDLE));

    a_r8_line_starts_save: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pwr_good && !hsb_in) |=> (state_q == ST_SSETUP));

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
    import nvs_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic                     host_re,
    input  logic                     oe,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [7:0]               din,
    input  nvs_op_e                  op,
    input  logic [$clog2(DEPTH)-1:0] xidx,
    output logic [7:0]               dout,
    output logic                     dout_en
);

    logic [7:0] sram   [DEPTH];
    logic [7:0] shadow [DEPTH];

    // Working array: host writes, wipe and reload phases
    always_ff @(posedge clk) begin
        if (host_we) begin
            sram[idx] <= din;
        end else begin
            unique case (op)
                OP_WIPE: sram[xidx] <= 8'h00;
                OP_LOAD: sram[xidx] <= shadow[xidx];
                default: ;
            endcase
        end
    end

    // Shadow array: written only by the save phase
    always_ff @(posedge clk) begin
        if (op == OP_SAVE) shadow[xidx] <= sram[xidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end else if (host_re) begin
            dout    <= sram[idx];
            dout_en <= oe;
        end else begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end
    end

    a_r5_no_host_write_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |-> !host_we);

    a_r5_no_data_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |=> !dout_en);

endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DEPTH  = 256,
    parameter int OVH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hsb_in,
    output logic              hsb_drive_low,
    input  logic              pwr_good,
    output logic              busy
);

    localparam int IDX_W = $clog2(DEPTH);

    nvs_state_e       state;
    nvs_op_e          op;
    logic [IDX_W-1:0] xidx;
    logic             host_ok, acc, wr, rd, save_hit, load_hit;

    assign host_ok = (state == ST_IDLE) && pwr_good && hsb_in;
    assign acc     = host_ok && !ce_n;
    assign wr      = acc && !we_n;
    assign rd      = acc && we_n;

    nvs_cmd_detect #(.ADDR_W(ADDR_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (host_ok),
        .acc      (acc),
        .rd       (rd),
        .addr     (addr),
        .save_hit (save_hit),
        .load_hit (load_hit)
    );

    nvs_ctrl_fsm #(.DEPTH(DEPTH), .OVH(OVH)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .hsb_in        (hsb_in),
        .save_req      (save_hit),
        .load_req      (load_hit),
        .wr_accept     (wr),
        .state_q       (state),
        .busy          (busy),
        .hsb_drive_low (hsb_drive_low),
        .op            (op),
        .xidx          (xidx)
    );

    nvs_arrays #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_we (wr),
        .host_re (rd),
        .oe      (!oe_n),
        .idx     (addr[IDX_W-1:0]),
        .din     (din),
        .op      (op),
        .xidx    (xidx),
        .dout    (dout),
        .dout_en (dout_en)
    );

    a_r11_no_access_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good || !hsb_in) |=> !dout_en);

    a_r5_busy_pulls_line: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !hsb_in);

endmodule

// File: tb/nvsram_ctl_test.sv
`timescale 1ns/1ps
module nvsram_ctl_test;

    localparam int AW  = 15;
    localparam int D   = 16;
    localparam int OVH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          pwr_good = 1'b0;
    logic          hsb_pull = 1'b0;
    logic [7:0]    dout;
    logic          dout_en, hsb_drv, busy;
    wire           hsb_line = !(hsb_pull || hsb_drv);

    int   n_chk = 0, n_fail = 0;
    logic [7:0] m_sram [D];
    logic [7:0] m_shadow [D];
    bit   m_dirty = 0;

    int seq_pre [5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

    always #2.5 clk = ~clk;

    nvsram_ctl #(.ADDR_W(AW), .DEPTH(D), .OVH(OVH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hsb_in(hsb_line), .hsb_drive_low(hsb_drv), .pwr_good(pwr_good),
        .busy(busy)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(int a, int d);
        addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0; oe_n = 1;
        tick(); idle();
        m_sram[a % D] = 8'(d);
        m_dirty = 1;
        chk("R1 write keeps idle", busy, 0);
    endtask

    task automatic rd(int a, bit oe, string req);
        addr = AW'(a); ce_n = 0; we_n = 1; oe_n = !oe;
        tick(); idle();
        chk(req, dout_en, oe);
        if (oe) chk(req, dout, m_sram[a % D]);
    endtask

    // busy must already be visible at the current negedge
    task automatic busy_win(int n, string req, bit end_busy);
        chk(req, busy, 1);
        chk("R5 line pulled", hsb_drv, 1);
        for (int i = 1; i < n; i++) begin
            addr = AW'(i); din = 8'hA5; ce_n = 0; we_n = i[0]; oe_n = 0;
            tick();
            chk(req, busy, 1);
            chk("R5 read ignored", dout_en, 0);
            chk("R5 read data zero", dout, 0);
        end
        idle();
        tick();
        chk(req, busy, end_busy);
    endtask

    task automatic seq(int last, string req);
        for (int s = 0; s < 5; s++) rd(seq_pre[s], 1, req);
        rd(last, 1, req);
    endtask

    task automatic verify_all(string req);
        for (int i = 0; i < D; i++) rd(i, 1, req);
    endtask

    task automatic after_save();
        for (int i = 0; i < D; i++) m_shadow[i] = m_sram[i];
        m_dirty = 0;
    endtask

    task automatic after_load();
        for (int i = 0; i < D; i++) m_sram[i] = m_shadow[i];
        m_dirty = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 reset waits busy", busy, 1);
        chk("R10 reset line low", hsb_drv, 1);
        chk("R10 reset no data", dout_en, 0);
        tick();
        chk("R10 stays off", busy, 1);

        // R10: power-up recall
        pwr_good = 1'b1;
        tick();
        busy_win(OVH + 2 * D, "R10 power-up recall", 0);
        for (int i = 0; i < D; i++) begin
            addr = AW'(i); ce_n = 0; we_n = 1; oe_n = 0;
            tick(); idle();
            m_sram[i] = dout; m_shadow[i] = dout;
        end

        // R1: plain SRAM use
        for (int i = 0; i < D; i++) wr(i, i * 7 + 3);
        rd(5, 1, "R1 read");
        rd(12, 1, "R1 read");
        rd(2, 0, "R1 oe high gives no data");

        // R2 + R6: software store
        seq('h0FC0, "R2 store sequence");
        busy_win(OVH + D, "R6 store length", 0);
        after_save();
        verify_all("R5 writes dropped during store");

        // R3 + R6: software recall
        for (int i = 0; i < D; i++) wr(i, 8'hF0 ^ i);
        seq('h0C63, "R3 recall sequence");
        busy_win(OVH + 2 * D, "R6 recall length", 0);
        after_load();
        verify_all("R3 recall restores shadow");

        // R7: repeat recall, shadow unchanged
        wr(4, 8'h3C);
        seq('h0C63, "R7 second recall");
        busy_win(OVH + 2 * D, "R7 second recall", 0);
        after_load();
        verify_all("R7 shadow unchanged");

        // R4: write mid-sequence aborts
        for (int s = 0; s < 3; s++) rd(seq_pre[s], 1, "R4 seq");
        wr(9, 8'h77);
        for (int s = 3; s < 5; s++) rd(seq_pre[s], 1, "R4 seq");
        rd('h0C63, 1, "R4 seq");
        chk("R4 write aborts", busy, 0);

        // R4: stray read aborts
        rd(seq_pre[0], 1, "R4 seq");
        rd(seq_pre[1], 1, "R4 seq");
        rd(1, 1, "R4 seq");
        for (int s = 2; s < 5; s++) rd(seq_pre[s], 1, "R4 seq");
        rd('h0C63, 1, "R4 seq");
        chk("R4 stray read aborts", busy, 0);

        // R4: restart on step one, idle gaps tolerated
        rd(seq_pre[0], 1, "R4 seq");
        for (int s = 0; s < 5; s++) begin
            rd(seq_pre[s], 1, "R4 seq");
            tick();
        end
        rd('h0C63, 1, "R4 restart");
        busy_win(OVH + 2 * D, "R4 restart triggers", 0);
        after_load();
        verify_all("R4 recall after restart");

        // R9: clean software store skipped
        seq('h0FC0, "R9 clean store");
        chk("R9 clean store skipped", busy, 0);

        // R8: line-forced store while clean
        hsb_pull = 1'b1;
        tick();
        hsb_pull = 1'b0;
        busy_win(OVH + D, "R8 forced store", 0);
        after_save();

        // R9: clean power loss goes straight to OFF
        pwr_good = 1'b0;
        tick();
        chk("R9 clean power loss", busy, 1);
        tick();
        chk("R10 off holds", busy, 1);
        pwr_good = 1'b1;
        tick();
        busy_win(OVH + 2 * D, "R10 recall after clean loss", 0);
        after_load();
        verify_all("R9 skipped store kept shadow");

        // R10 + R11: dirty power loss with a write in the same clock
        for (int i = 0; i < D; i++) wr(i, 8'h40 + i * 3);
        pwr_good = 1'b0;
        hsb_pull = 1'b1;
        addr = '0; din = 8'h5A; ce_n = 0; we_n = 0;
        tick();
        idle();
        hsb_pull = 1'b0;
        busy_win(OVH + D, "R10 power-loss store", 1);
        after_save();
        tick();
        chk("R10 off after store", busy, 1);
        pwr_good = 1'b1;
        tick();
        busy_win(OVH + 2 * D, "R10 power-up recall", 0);
        after_load();
        verify_all("R11 event-cycle write dropped");

        finish_run();
    end

endmodule